// File: doc/BRIEF.md
# Sideband Register Bus Bridge

This block sits between a host that issues 64-bit memory-mapped accesses and a narrow sideband register bus that reaches configuration registers spread across a chip. Each chip owns a window of 2^35 bytes. The window base is `0x3_FC00_0000_0000 + chip_id * 2^35`, and the chip identity comes from a strap. An access that lands in the window is reduced to its offset inside the window. The offset is then turned into a 32-bit register address by one of two translation schemes, chosen by a generation strap.

A handful of reserved register addresses are answered by the bridge itself: a read-only chip identification word, and a few error and bus-unit registers that read as zero or swallow writes. Every other access goes to the downstream register bus over a valid/ready request channel and a response channel. Only one access is in flight at a time. When an access completes, the bridge records the outcome in two sticky status bits, done and fail, rather than raising a bus error. The host clears these bits by writing ones to a separate clear port.

Top module: `sbr_bridge`

## Requirements
- R1: An access whose address bits 49:35 differ from `0x7F80 + chip_id` is never acknowledged (`h_ready` stays low) and is not forwarded.
- R2: With `strap_gen_b = 0`, the register address is `((off >> 4) & ~0xF) | ((off >> 3) & 0xF)`, where `off` is the address masked to the low 35 bits. Offset bits 7 and 2:0 are ignored.
- R3: With `strap_gen_b = 1`, the register address is `off >> 3`.
- R4: A read of register `0xF000F` returns the `IDENT` parameter without forwarding. A write to it is dropped without forwarding and reports done only.
- R5: Reads of registers `0x1010C00`, `0x1010C03`, `0x2020007`, `0x2020009`, `0x202000F` and `0x2013F00` through `0x2013F07` return zero without forwarding and report done only. Neighbouring registers outside these sets are forwarded.
- R6: Writes to registers `0x1010C00` through `0x1010C05`, `0x2020007`, `0x2020009` and `0x202000F` are dropped without forwarding and report done only.
- R7: Any other full-width access is forwarded once, carrying the translated address, the write flag and the host write data unchanged. A successful read returns the downstream data, and the access sets done only.
- R8: If the downstream response flags an error, the access sets both fail and done, and the host read data is zero.
- R9: Status bit 0 is done and bit 1 is fail. Both reset to 0 and stay set until the host writes a 1 to the matching bit of `st_clr`. When a set and a clear land in the same cycle, the set wins.
- R10: An in-window access with `h_bytes` other than 8 is not forwarded. It is acknowledged with zero read data and sets fail and done.
- R11: While a forwarded access is pending, `h_ready` stays low. `d_req_valid` holds with a stable address and data until `d_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_gen_b | input | 1 | Translation scheme select (0: interleaved, 1: linear) |
| strap_chip_id | input | CID_W | Chip identity that places the window |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | One-cycle acknowledge carrying read data |
| h_write | input | 1 | Host access is a write |
| h_addr | input | HA_W | Host byte address |
| h_bytes | input | 4 | Access size in bytes |
| h_wdata | input | 64 | Host write data (big-endian lane order) |
| h_rdata | output | 64 | Host read data |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream request accepted |
| d_req_write | output | 1 | Downstream request is a write |
| d_req_addr | output | RA_W | Downstream register address |
| d_req_wdata | output | 64 | Downstream write data |
| d_rsp_valid | input | 1 | Downstream response valid |
| d_rsp_rdata | input | 64 | Downstream read data |
| d_rsp_err | input | 1 | Downstream access failed |
| st_clr | input | 2 | Write-one-to-clear for status bits (bit 0 done, bit 1 fail) |
| st_done | output | 1 | Sticky done status |
| st_fail | output | 1 | Sticky fail status |

## Verification
The bench uses the default parameters: a 50-bit host address, a 2^35-byte window, a 4-bit chip identity and 32-bit register addresses. With these values it can check window boundaries exactly, just below and just above several chip windows, including the highest chip identity. For each translation strap it sweeps about forty offsets whose ignored bits are scattered. It also reaches every reserved register and its nearest forwarded neighbours by building the host address arithmetically from the register address. A downstream model with varying stall and an error switch covers the hold, pending-ready and fail paths.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_RESP = 2'd3
  } sbr_state_t;

  localparam int unsigned FULL_BYTES = 8;
  localparam int unsigned ST_DONE_BIT = 0;
  localparam int unsigned ST_FAIL_BIT = 1;
endpackage

// File: rtl/sbr_xlate.sv
module sbr_xlate #(
  parameter int unsigned HA_W   = 50,
  parameter int unsigned WIN_LG = 35,
  parameter int unsigned CID_W  = 4,
  parameter int unsigned RA_W   = 32,
  parameter logic [63:0] BASE   = 64'h0003_FC00_0000_0000
) (
  input  logic [HA_W-1:0]  addr,
  input  logic [CID_W-1:0] chip_id,
  input  logic             gen_b,
  output logic             in_win,
  output logic [RA_W-1:0]  reg_addr
);
  localparam int unsigned HI_W = HA_W - WIN_LG;
  localparam logic [HI_W-1:0] BASE_BLK = BASE[HA_W-1:WIN_LG];

  logic [HI_W-1:0]   blk;
  logic [WIN_LG-1:0] off;
  logic [RA_W-1:0]   ra_inter;
  logic [RA_W-1:0]   ra_linear;
  logic              unused_bits;

  assign blk    = BASE_BLK + HI_W'(chip_id);
  assign in_win = (addr[HA_W-1:WIN_LG] == blk);
  assign off    = addr[WIN_LG-1:0];

  // interleaved: upper offset moves down four, bits 6:3 fill the low nibble
  assign ra_inter  = RA_W'({off[WIN_LG-1:8], off[6:3]});
  assign ra_linear = RA_W'(off[WIN_LG-1:3]);
  assign reg_addr  = gen_b ? ra_linear : ra_inter;

  assign unused_bits = ^{off[7], off[2:0]};
endmodule

// File: rtl/sbr_local.sv
module sbr_local #(
  parameter int unsigned RA_W  = 32,
  parameter logic [63:0] IDENT = 64'h5A3C_0F12_7700_0001
) (
  input  logic [RA_W-1:0] reg_addr,
  input  logic            wr,
  output logic            hit,
  output logic [63:0]     rdata
);
  localparam logic [RA_W-1:0] A_IDENT = RA_W'(32'h000F_000F);
  localparam logic [RA_W-1:0] A_FIR   = RA_W'(32'h0101_0C00);
  localparam logic [RA_W-1:0] A_UNIT  = RA_W'(32'h0202_0000);
  localparam logic [RA_W-1:0] A_BRG   = RA_W'(32'h0201_3F00);

  logic is_ident, fir_rd, fir_wr, unit_hit, brg_hit;

  assign is_ident = (reg_addr == A_IDENT);
  assign fir_rd   = (reg_addr == A_FIR) || (reg_addr == A_FIR + RA_W'(3));
  assign fir_wr   = (reg_addr >= A_FIR) && (reg_addr <= A_FIR + RA_W'(5));
  assign unit_hit = (reg_addr == A_UNIT + RA_W'(7)) ||
                    (reg_addr == A_UNIT + RA_W'(9)) ||
                    (reg_addr == A_UNIT + RA_W'(15));
  assign brg_hit  = (reg_addr >= A_BRG) && (reg_addr <= A_BRG + RA_W'(7));

  always_comb begin
    if (wr) begin
      hit = is_ident || fir_wr || unit_hit;
    end else begin
      hit = is_ident || fir_rd || unit_hit || brg_hit;
    end
    rdata = (is_ident && !wr) ? IDENT : 64'd0;
  end
endmodule

// File: rtl/sbr_status.sv
module sbr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_done,
  input  logic       set_fail,
  input  logic [1:0] clr,
  output logic       st_done,
  output logic       st_fail
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_done <= 1'b0;
      st_fail <= 1'b0;
    end else begin
      st_done <= set_done | (st_done & ~clr[sbr_pkg::ST_DONE_BIT]);
      st_fail <= set_fail | (st_fail & ~clr[sbr_pkg::ST_FAIL_BIT]);
    end
  end

  p_sticky_done_r9: assert property (@(posedge clk) disable iff (rst)
    (st_done && !clr[0]) |=> st_done);
  p_sticky_fail_r9: assert property (@(posedge clk) disable iff (rst)
    (st_fail && !clr[1]) |=> st_fail);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_done |=> st_done);
endmodule

// File: rtl/sbr_bridge.sv
module sbr_bridge #(
  parameter int unsigned HA_W   = 50,
  parameter int unsigned WIN_LG = 35,
  parameter int unsigned CID_W  = 4,
  parameter int unsigned RA_W   = 32,
  parameter logic [63:0] BASE   = 64'h0003_FC00_0000_0000,
  parameter logic [63:0] IDENT  = 64'h5A3C_0F12_7700_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_gen_b,
  input  logic [CID_W-1:0] strap_chip_id,
  input  logic             h_valid,
  output logic             h_ready,
  input  logic             h_write,
  input  logic [HA_W-1:0]  h_addr,
  input  logic [3:0]       h_bytes,
  input  logic [63:0]      h_wdata,
  output logic [63:0]      h_rdata,
  output logic             d_req_valid,
  input  logic             d_req_ready,
  output logic             d_req_write,
  output logic [RA_W-1:0]  d_req_addr,
  output logic [63:0]      d_req_wdata,
  input  logic             d_rsp_valid,
  input  logic [63:0]      d_rsp_rdata,
  input  logic             d_rsp_err,
  input  logic [1:0]       st_clr,
  output logic             st_done,
  output logic             st_fail
);
  import sbr_pkg::*;

  sbr_state_t      state;
  logic            in_win;
  logic [RA_W-1:0] reg_addr;
  logic            loc_hit;
  logic [63:0]     loc_rdata;
  logic            bad_size;
  logic            take;
  logic            set_done, set_fail;

  sbr_xlate #(.HA_W(HA_W), .WIN_LG(WIN_LG), .CID_W(CID_W), .RA_W(RA_W), .BASE(BASE)) u_xlate (
    .addr(h_addr), .chip_id(strap_chip_id), .gen_b(strap_gen_b),
    .in_win(in_win), .reg_addr(reg_addr)
  );

  sbr_local #(.RA_W(RA_W), .IDENT(IDENT)) u_local (
    .reg_addr(reg_addr), .wr(h_write), .hit(loc_hit), .rdata(loc_rdata)
  );

  assign bad_size = (h_bytes != 4'(FULL_BYTES));
  assign take     = (state == S_IDLE) && h_valid && in_win;

  always_comb begin
    set_done = (take && (bad_size || loc_hit)) || (state == S_WAIT && d_rsp_valid);
    set_fail = (take && bad_size) || (state == S_WAIT && d_rsp_valid && d_rsp_err);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      h_ready     <= 1'b0;
      h_rdata     <= '0;
      d_req_valid <= 1'b0;
      d_req_write <= 1'b0;
      d_req_addr  <= '0;
      d_req_wdata <= '0;
    end else begin
      h_ready <= 1'b0;
      case (state)
        S_IDLE: begin
          if (take) begin
            if (bad_size) begin
              h_ready <= 1'b1;
              h_rdata <= '0;
              state   <= S_RESP;
            end else if (loc_hit) begin
              h_ready <= 1'b1;
              h_rdata <= loc_rdata;
              state   <= S_RESP;
            end else begin
              d_req_valid <= 1'b1;
              d_req_write <= h_write;
              d_req_addr  <= reg_addr;
              d_req_wdata <= h_wdata;
              state       <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (d_req_ready) begin
            d_req_valid <= 1'b0;
            state       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (d_rsp_valid) begin
            h_ready <= 1'b1;
            h_rdata <= (d_rsp_err || d_req_write) ? 64'd0 : d_rsp_rdata;
            state   <= S_RESP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  sbr_status u_status (
    .clk(clk), .rst(rst), .set_done(set_done), .set_fail(set_fail),
    .clr(st_clr), .st_done(st_done), .st_fail(st_fail)
  );

  p_outside_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && h_valid && !in_win) |=> (!h_ready && !d_req_valid));
  p_short_r10: assert property (@(posedge clk) disable iff (rst)
    (take && bad_size) |=> (h_ready && h_rdata == 64'd0 && !d_req_valid && st_fail));
  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && d_rsp_valid && d_rsp_err) |=> (h_ready && h_rdata == 64'd0 && st_fail && st_done));
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (d_req_valid && !d_req_ready) |=> (d_req_valid && $stable(d_req_addr) && $stable(d_req_wdata)));
  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    d_req_valid |-> !h_ready);
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    h_ready |=> !h_ready);
endmodule

// File: tb/sbr_bridge_bench.sv
`timescale 1ns/1ps
module sbr_bridge_bench;
  localparam int unsigned HA_W = 50;
  localparam int unsigned WIN_LG = 35;
  localparam int unsigned CID_W = 4;
  localparam int unsigned RA_W = 32;
  localparam logic [63:0] BASE = 64'h0003_FC00_0000_0000;
  localparam logic [63:0] IDENT = 64'h5A3C_0F12_7700_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_gen_b = 1'b0;
  logic [CID_W-1:0] strap_chip_id = '0;
  logic h_valid = 1'b0, h_write = 1'b0;
  logic [HA_W-1:0] h_addr = '0;
  logic [3:0] h_bytes = 4'd8;
  logic [63:0] h_wdata = '0;
  logic h_ready;
  logic [63:0] h_rdata;
  logic d_req_valid, d_req_write;
  logic [RA_W-1:0] d_req_addr;
  logic [63:0] d_req_wdata;
  logic d_req_ready = 1'b0, d_rsp_valid = 1'b0, d_rsp_err = 1'b0;
  logic [63:0] d_rsp_rdata = '0;
  logic [1:0] st_clr = 2'b00;
  logic st_done, st_fail;

  always #2 clk = ~clk;

  sbr_bridge #(.HA_W(HA_W), .WIN_LG(WIN_LG), .CID_W(CID_W), .RA_W(RA_W),
               .BASE(BASE), .IDENT(IDENT)) u_sbr_bridge (
    .clk(clk), .rst(rst), .strap_gen_b(strap_gen_b), .strap_chip_id(strap_chip_id),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_addr(h_addr),
    .h_bytes(h_bytes), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_write(d_req_write),
    .d_req_addr(d_req_addr), .d_req_wdata(d_req_wdata),
    .d_rsp_valid(d_rsp_valid), .d_rsp_rdata(d_rsp_rdata), .d_rsp_err(d_rsp_err),
    .st_clr(st_clr), .st_done(st_done), .st_fail(st_fail)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  // downstream register bus model
  int fwd_cnt = 0;
  int mst = 0;
  int stall_cfg = 0;
  int stall_left = 0;
  logic err_mode = 1'b0;
  logic [RA_W-1:0] cap_addr = '0;
  logic cap_wr = 1'b0;
  logic [63:0] cap_wdata = '0;

  always @(negedge clk) begin
    d_req_ready = 1'b0;
    d_rsp_valid = 1'b0;
    if (mst == 0 && d_req_valid) begin
      if (stall_left == 0) begin
        cap_addr = d_req_addr;
        cap_wr = d_req_write;
        cap_wdata = d_req_wdata;
        fwd_cnt++;
        chk("R11 host ready low while forwarded access pending", 64'(h_ready), 64'd0);
        d_req_ready = 1'b1;
        mst = 1;
      end else begin
        stall_left--;
      end
    end else if (mst == 1) begin
      d_rsp_valid = 1'b1;
      d_rsp_err = err_mode;
      d_rsp_rdata = err_mode ? 64'hBAD0_BAD0_BAD0_BAD0 : {cap_addr, ~cap_addr};
      mst = 2;
    end else if (mst == 2) begin
      mst = 0;
    end
    if (!d_req_valid && mst == 0) stall_left = stall_cfg;
  end

  function automatic logic [31:0] exp_ra(input logic [HA_W-1:0] a, input logic gb);
    logic [63:0] o;
    o = 64'(a) & ((64'd1 << WIN_LG) - 64'd1);
    if (gb) return 32'(o >> 3);
    return 32'(((o >> 4) & ~64'hF) | ((o >> 3) & 64'hF));
  endfunction

  function automatic logic [HA_W-1:0] host_of(input logic [31:0] ra, input logic gb,
                                               input logic [CID_W-1:0] cid);
    logic [63:0] o;
    if (gb) o = 64'(ra) << 3;
    else o = ((64'(ra) & ~64'hF) << 4) | ((64'(ra) & 64'hF) << 3);
    return HA_W'(BASE + (64'(cid) << WIN_LG) + o);
  endfunction

  function automatic logic loc_rd(input logic [31:0] ra);
    return ra == 32'h000F000F || ra == 32'h01010C00 || ra == 32'h01010C03 ||
           ra == 32'h02020007 || ra == 32'h02020009 || ra == 32'h0202000F ||
           (ra >= 32'h02013F00 && ra <= 32'h02013F07);
  endfunction

  function automatic logic loc_wr(input logic [31:0] ra);
    return ra == 32'h000F000F || (ra >= 32'h01010C00 && ra <= 32'h01010C05) ||
           ra == 32'h02020007 || ra == 32'h02020009 || ra == 32'h0202000F;
  endfunction

  task automatic xfer(input logic [HA_W-1:0] a, input logic wr, input logic [63:0] wd,
                      input logic [3:0] nb, input logic hold_clr);
    int f0;
    logic got;
    logic [63:0] rd;
    logic inwin;
    logic [31:0] ra;
    logic [63:0] erd;
    @(negedge clk); st_clr = 2'b11;
    @(negedge clk); st_clr = hold_clr ? 2'b11 : 2'b00;
    f0 = fwd_cnt;
    h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = wd; h_bytes = nb;
    got = 1'b0; rd = '0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (h_ready) begin got = 1'b1; rd = h_rdata; break; end
    end
    h_valid = 1'b0;
    inwin = (64'(a) >> WIN_LG) == ((BASE >> WIN_LG) + 64'(strap_chip_id));
    ra = exp_ra(a, strap_gen_b);
    if (!inwin) begin
      chk("R1 outside window acknowledged", 64'(got), 64'd0);
      chk("R1 outside window forwarded", 64'(fwd_cnt - f0), 64'd0);
    end else if (nb != 4'd8) begin
      chk("R10 short access ack", 64'(got), 64'd1);
      chk("R10 short access forwarded", 64'(fwd_cnt - f0), 64'd0);
      chk("R10 short access rdata", rd, 64'd0);
      chk("R10 short access status", {62'd0, st_fail, st_done}, 64'd3);
    end else if (wr ? loc_wr(ra) : loc_rd(ra)) begin
      erd = (!wr && ra == 32'h000F000F) ? IDENT : 64'd0;
      chk(wr ? "R6 local write ack" : "R5 local read ack", 64'(got), 64'd1);
      chk(wr ? "R6 local write forwarded" : "R5 local read forwarded", 64'(fwd_cnt - f0), 64'd0);
      chk(ra == 32'h000F000F ? "R4 ident rdata" : "R5 local rdata", rd, wr ? 64'd0 : erd);
      chk("R4 local status done only", {62'd0, st_fail, st_done}, 64'd1);
    end else begin
      chk("R7 forward ack", 64'(got), 64'd1);
      chk("R7 forwarded once", 64'(fwd_cnt - f0), 64'd1);
      chk(strap_gen_b ? "R3 linear address" : "R2 interleaved address", 64'(cap_addr), 64'(ra));
      chk("R7 write flag", 64'(cap_wr), 64'(wr));
      if (wr) chk("R7 write data", cap_wdata, wd);
      if (err_mode) begin
        chk("R8 error rdata", rd, 64'd0);
        chk("R8 error status", {62'd0, st_fail, st_done}, 64'd3);
      end else begin
        if (!wr) chk("R7 read data", rd, {ra, ~ra});
        chk("R7 status done only", {62'd0, st_fail, st_done}, 64'd1);
      end
    end
    if (hold_clr) begin
      @(negedge clk);
      chk("R9 clear after set", {62'd0, st_fail, st_done}, 64'd0);
      st_clr = 2'b00;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] o;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R9 reset done", 64'(st_done), 64'd0);
    chk("R9 reset fail", 64'(st_fail), 64'd0);
    chk("R11 reset request idle", 64'(d_req_valid), 64'd0);
    chk("R7 reset ready", 64'(h_ready), 64'd0);
    rst = 1'b0;
    strap_chip_id = 4'd3;

    // translation sweep, both generations, writes then reads
    for (int g = 0; g < 2; g++) begin
      strap_gen_b = g[0];
      for (int i = 0; i < 40; i++) begin
        stall_cfg = i % 3;
        o = (64'(i) * 64'h0000_0001_3579_BDF1 + 64'(i * 5)) & ((64'd1 << WIN_LG) - 64'd1);
        xfer(HA_W'(BASE + (64'd3 << WIN_LG) + o), 1'b1, {32'(i), 32'hC0DE_0000 + 32'(g)}, 4'd8, 1'b0);
        xfer(HA_W'(BASE + (64'd3 << WIN_LG) + o), 1'b0, 64'd0, 4'd8, 1'b0);
      end
    end

    // reserved registers and their neighbours
    for (int g = 0; g < 2; g++) begin
      strap_gen_b = g[0];
      for (int k = 0; k < 10; k++) begin
        r = 32'h01010C00 + 32'(k);
        xfer(host_of(r, g[0], 4'd3), 1'b0, 64'd0, 4'd8, 1'b0);
        xfer(host_of(r, g[0], 4'd3), 1'b1, 64'h1111_2222_3333_4444, 4'd8, 1'b0);
        r = 32'h02013F00 + 32'(k);
        xfer(host_of(r, g[0], 4'd3), 1'b0, 64'd0, 4'd8, 1'b0);
        xfer(host_of(r, g[0], 4'd3), 1'b1, 64'h5555_6666_7777_8888, 4'd8, 1'b0);
      end
      for (int k = 6; k < 17; k++) begin
        r = 32'h02020000 + 32'(k);
        xfer(host_of(r, g[0], 4'd3), 1'b0, 64'd0, 4'd8, 1'b0);
        xfer(host_of(r, g[0], 4'd3), 1'b1, 64'h9999_AAAA_BBBB_CCCC, 4'd8, 1'b0);
      end
      xfer(host_of(32'h000F000F, g[0], 4'd3), 1'b0, 64'd0, 4'd8, 1'b0);
      xfer(host_of(32'h000F000F, g[0], 4'd3), 1'b1, 64'hFFFF_0000_FFFF_0000, 4'd8, 1'b0);
      xfer(host_of(32'h000F000E, g[0], 4'd3), 1'b0, 64'd0, 4'd8, 1'b0);
    end

    // downstream error
    err_mode = 1'b1;
    xfer(host_of(32'h00000123, 1'b0, 4'd3), 1'b0, 64'd0, 4'd8, 1'b0);
    xfer(host_of(32'h00000456, 1'b0, 4'd3), 1'b1, 64'h0102_0304_0506_0708, 4'd8, 1'b0);
    err_mode = 1'b0;

    // partial accesses
    for (int b = 0; b < 16; b++) begin
      if (b != 8) xfer(host_of(32'h00000040, 1'b1, 4'd3), b[0], 64'd7, 4'(b), 1'b0);
    end

    // window boundaries for several chip identities
    for (int c = 0; c < 16; c += 5) begin
      strap_chip_id = 4'(c);
      xfer(HA_W'(BASE + (64'(c) << WIN_LG)), 1'b0, 64'd0, 4'd8, 1'b0);
      xfer(HA_W'(BASE + (64'(c) << WIN_LG) - 64'd8), 1'b0, 64'd0, 4'd8, 1'b0);
      xfer(HA_W'(BASE + (64'(c + 1) << WIN_LG)), 1'b1, 64'd1, 4'd8, 1'b0);
      xfer(HA_W'(BASE + (64'(c + 1) << WIN_LG) - 64'd8), 1'b0, 64'd0, 4'd8, 1'b0);
    end

    // sticky status and write-one-to-clear
    strap_chip_id = 4'd3;
    xfer(host_of(32'h00000010, 1'b0, 4'd3), 1'b1, 64'd0, 4'd3, 1'b0);
    repeat (5) @(negedge clk);
    chk("R9 sticky over idle cycles", {62'd0, st_fail, st_done}, 64'd3);
    st_clr = 2'b10; @(negedge clk); st_clr = 2'b00;
    chk("R9 clear fail only", {62'd0, st_fail, st_done}, 64'd1);
    st_clr = 2'b01; @(negedge clk); st_clr = 2'b00;
    chk("R9 clear done", {62'd0, st_fail, st_done}, 64'd0);
    xfer(host_of(32'h000F000F, 1'b0, 4'd3), 1'b0, 64'd0, 4'd8, 1'b1);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule